// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a set of sticky flags that tell firmware why the device last went through reset or changed its power state. Single-cycle pulses arrive from the reset logic, the watchdog, the power-save instruction path and the supply monitors. A power-on reset input brings every flag to its starting value. The flags are read and written through two 16-bit registers on a simple register port. The read is combinational and selected by a one-bit address.

The primary register (address 0) holds the core reset and power-state causes. Hardware sets these flags, and software may set or clear any of them with a plain write. The watchdog flag is also cleared by the clear-watchdog instruction and by any power-save instruction. The secondary register (address 1) holds supply- and battery-domain flags. Only hardware can set them, and software can only clear them. Whenever a hardware set and a clear reach the same flag in one cycle, the set wins, so no cause is lost.

Top module: `rc_status_top`

## Requirements
- R1: While `por_i` is high, the primary register takes the value 0x0003 (brown-out bit 1 and power-on bit 0 set) and the secondary register takes 0x000E (bits 3, 2 and 1 set, bit 0 clear). These values are visible on the first cycle after `por_i` falls.
- R2: A pulse on a primary event input sets its flag at the next clock edge: trap bit 15, illegal access bit 14, configuration mismatch bit 9, external pin bit 7, software reset bit 6, watchdog timeout bit 4, brown-out bit 1.
- R3: A power-save instruction pulse (`instr_pwrsav`) behaves by mode. With `pwrsav_mode`=0 it sets the sleep bit 3, and also sets the deep-sleep bit 10 when `deep_sleep_en` is 1. With `pwrsav_mode`=1 it sets the idle bit 2.
- R4: The watchdog bit 4 is cleared by an `instr_clrwdt` pulse or by any `instr_pwrsav` pulse.
- R5: A write to address 0 loads every implemented primary bit (15, 14, 10, 9, 7, 6, 4..0) from `reg_wdata`, setting or clearing it. Bits 13, 12, 11, 8 and 5 always read 0.
- R6: A write to address 1 clears each secondary bit 3..0 whose `reg_wdata` bit is 0 and leaves it unchanged where the data bit is 1. A write never sets a secondary bit.
- R7: Secondary bits 15..4 always read 0, whatever is written.
- R8: Secondary set pulses go to these bits: `ev_vdd_bor` to bit 3, `ev_vdd_por` to bit 2, `ev_vbat_por` to bit 1, `ev_vbat_exit` to bit 0. Each sets its bit at the next clock edge.
- R9: A hardware set wins over a software write or an instruction clear aimed at the same flag in the same cycle.
- R10: `reg_rdata` shows the primary register when `reg_addr`=0 and the secondary register when `reg_addr`=1, in the same cycle. A write to one address leaves the other register unchanged.
- R11: With no event, instruction or write, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| ev_trap | input | 1 | Trap conflict pulse |
| ev_illegal | input | 1 | Illegal opcode or uninitialised register access pulse |
| ev_cfg_mismatch | input | 1 | Configuration mismatch pulse |
| ev_ext_pin | input | 1 | External reset pin pulse |
| ev_sw_reset | input | 1 | Software reset instruction pulse |
| ev_wdt_timeout | input | 1 | Watchdog timeout pulse |
| ev_brownout | input | 1 | Core brown-out pulse |
| instr_clrwdt | input | 1 | Clear-watchdog instruction executed |
| instr_pwrsav | input | 1 | Power-save instruction executed |
| pwrsav_mode | input | 1 | Power-save mode: 0 sleep, 1 idle |
| deep_sleep_en | input | 1 | Deep-sleep enable level |
| ev_vdd_bor | input | 1 | Supply brown-out pulse |
| ev_vdd_por | input | 1 | Supply power-on pulse |
| ev_vbat_por | input | 1 | Battery-domain power-on pulse |
| ev_vbat_exit | input | 1 | Power-on exit with battery present pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 primary, 1 secondary |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |

## Verification
Each primary and secondary event is pulsed alone on top of the flags already collected, so a wrong bit position or a flag that fails to stay set shows up as a mismatched word. The primary write path is swept with every single-bit pattern and an all-ones word, which separates implemented bits from unused ones and shows that software can both set and clear. The secondary clear path is swept with all sixteen low patterns from an all-set start, with the upper bits of the data held high, to tell clear-only behaviour from a plain load. Events are also made to collide with writes and instruction clears, checking that the set wins in each pairing.

// File: rtl/rc_status_pkg.sv
package rc_status_pkg;
  localparam int REG_W = 16;

  // Primary register bit positions
  localparam int P_TRAP   = 15;
  localparam int P_ILLOP  = 14;
  localparam int P_DEEP   = 10;
  localparam int P_CFGMM  = 9;
  localparam int P_EXTPIN = 7;
  localparam int P_SWRST  = 6;
  localparam int P_WDT    = 4;
  localparam int P_SLEEP  = 3;
  localparam int P_IDLE   = 2;
  localparam int P_BOR    = 1;
  localparam int P_POR    = 0;

  // Secondary register bit positions
  localparam int S_VBOR  = 3;
  localparam int S_VPOR  = 2;
  localparam int S_BPOR  = 1;
  localparam int S_BEXIT = 0;
  localparam int S_FLAGS = 4;

  function automatic logic [REG_W-1:0] bitm(input int pos);
    logic [REG_W-1:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] prim_impl();
    return bitm(P_TRAP) | bitm(P_ILLOP) | bitm(P_DEEP) | bitm(P_CFGMM) |
           bitm(P_EXTPIN) | bitm(P_SWRST) | bitm(P_WDT) | bitm(P_SLEEP) |
           bitm(P_IDLE) | bitm(P_BOR) | bitm(P_POR);
  endfunction

  function automatic logic [REG_W-1:0] sec_impl();
    return REG_W'((1 << S_FLAGS) - 1);
  endfunction

  function automatic logic [REG_W-1:0] prim_rst();
    return bitm(P_BOR) | bitm(P_POR);
  endfunction

  function automatic logic [REG_W-1:0] sec_rst();
    return bitm(S_VBOR) | bitm(S_VPOR) | bitm(S_BPOR);
  endfunction

  // Next flag value: software term, then instruction clears, then hardware sets.
  function automatic logic [REG_W-1:0] flag_next(
      input logic [REG_W-1:0] sw_term,
      input logic [REG_W-1:0] hw_clr,
      input logic [REG_W-1:0] hw_set,
      input logic [REG_W-1:0] impl);
    return ((sw_term & ~hw_clr) | hw_set) & impl;
  endfunction
endpackage

// File: rtl/rc_event_decode.sv
module rc_event_decode
  import rc_status_pkg::*;
(
  input  logic             ev_trap,
  input  logic             ev_illegal,
  input  logic             ev_cfg_mismatch,
  input  logic             ev_ext_pin,
  input  logic             ev_sw_reset,
  input  logic             ev_wdt_timeout,
  input  logic             ev_brownout,
  input  logic             instr_clrwdt,
  input  logic             instr_pwrsav,
  input  logic             pwrsav_mode,
  input  logic             deep_sleep_en,
  input  logic             ev_vdd_bor,
  input  logic             ev_vdd_por,
  input  logic             ev_vbat_por,
  input  logic             ev_vbat_exit,
  output logic [REG_W-1:0] prim_set,
  output logic [REG_W-1:0] prim_clr,
  output logic [REG_W-1:0] sec_set
);
  logic pwrsav_sleep;
  logic pwrsav_idle;
  logic pwrsav_deep;
  logic wdt_clr;

  assign pwrsav_sleep = instr_pwrsav & ~pwrsav_mode;
  assign pwrsav_idle  = instr_pwrsav &  pwrsav_mode;
  assign pwrsav_deep  = pwrsav_sleep & deep_sleep_en;
  assign wdt_clr      = instr_clrwdt | instr_pwrsav;

  always_comb begin
    prim_set = '0;
    prim_set[P_TRAP]   = ev_trap;
    prim_set[P_ILLOP]  = ev_illegal;
    prim_set[P_CFGMM]  = ev_cfg_mismatch;
    prim_set[P_EXTPIN] = ev_ext_pin;
    prim_set[P_SWRST]  = ev_sw_reset;
    prim_set[P_WDT]    = ev_wdt_timeout;
    prim_set[P_BOR]    = ev_brownout;
    prim_set[P_SLEEP]  = pwrsav_sleep;
    prim_set[P_IDLE]   = pwrsav_idle;
    prim_set[P_DEEP]   = pwrsav_deep;

    prim_clr = '0;
    prim_clr[P_WDT] = wdt_clr;

    sec_set = '0;
    sec_set[S_VBOR]  = ev_vdd_bor;
    sec_set[S_VPOR]  = ev_vdd_por;
    sec_set[S_BPOR]  = ev_vbat_por;
    sec_set[S_BEXIT] = ev_vbat_exit;
  end
endmodule

// File: rtl/rc_flag_reg.sv
module rc_flag_reg
  import rc_status_pkg::*;
#(
  parameter int             W          = REG_W,
  parameter logic [W-1:0]   RST_VAL    = '0,
  parameter logic [W-1:0]   IMPL       = '1,
  parameter bit             CLEAR_ONLY = 1'b0
) (
  input  logic         clk,
  input  logic         por_i,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);
  logic [W-1:0] sw_val;
  logic [W-1:0] sw_term;
  logic [W-1:0] d;

  generate
    if (CLEAR_ONLY) begin : g_clear_only
      assign sw_val = q & wdata;
    end else begin : g_load
      assign sw_val = wdata;
    end
  endgenerate

  assign sw_term = we ? sw_val : q;
  assign d       = flag_next(sw_term, hw_clr, hw_set, IMPL);

  always_ff @(posedge clk) begin
    if (por_i) q <= RST_VAL & IMPL;
    else       q <= d;
  end
endmodule

// File: rtl/rc_status_top.sv
module rc_status_top
  import rc_status_pkg::*;
(
  input  logic             clk,
  input  logic             por_i,
  input  logic             ev_trap,
  input  logic             ev_illegal,
  input  logic             ev_cfg_mismatch,
  input  logic             ev_ext_pin,
  input  logic             ev_sw_reset,
  input  logic             ev_wdt_timeout,
  input  logic             ev_brownout,
  input  logic             instr_clrwdt,
  input  logic             instr_pwrsav,
  input  logic             pwrsav_mode,
  input  logic             deep_sleep_en,
  input  logic             ev_vdd_bor,
  input  logic             ev_vdd_por,
  input  logic             ev_vbat_por,
  input  logic             ev_vbat_exit,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata
);
  logic [REG_W-1:0] prim_set;
  logic [REG_W-1:0] prim_clr;
  logic [REG_W-1:0] sec_set;
  logic [REG_W-1:0] prim_q;
  logic [REG_W-1:0] sec_q;
  logic             prim_we;
  logic             sec_we;

  assign prim_we = reg_we & ~reg_addr;
  assign sec_we  = reg_we &  reg_addr;

  rc_event_decode u_dec (
    .ev_trap         (ev_trap),
    .ev_illegal      (ev_illegal),
    .ev_cfg_mismatch (ev_cfg_mismatch),
    .ev_ext_pin      (ev_ext_pin),
    .ev_sw_reset     (ev_sw_reset),
    .ev_wdt_timeout  (ev_wdt_timeout),
    .ev_brownout     (ev_brownout),
    .instr_clrwdt    (instr_clrwdt),
    .instr_pwrsav    (instr_pwrsav),
    .pwrsav_mode     (pwrsav_mode),
    .deep_sleep_en   (deep_sleep_en),
    .ev_vdd_bor      (ev_vdd_bor),
    .ev_vdd_por      (ev_vdd_por),
    .ev_vbat_por     (ev_vbat_por),
    .ev_vbat_exit    (ev_vbat_exit),
    .prim_set        (prim_set),
    .prim_clr        (prim_clr),
    .sec_set         (sec_set)
  );

  rc_flag_reg #(
    .W          (REG_W),
    .RST_VAL    (prim_rst()),
    .IMPL       (prim_impl()),
    .CLEAR_ONLY (1'b0)
  ) u_prim (
    .clk    (clk),
    .por_i  (por_i),
    .we     (prim_we),
    .wdata  (reg_wdata),
    .hw_set (prim_set),
    .hw_clr (prim_clr),
    .q      (prim_q)
  );

  rc_flag_reg #(
    .W          (REG_W),
    .RST_VAL    (sec_rst()),
    .IMPL       (sec_impl()),
    .CLEAR_ONLY (1'b1)
  ) u_sec (
    .clk    (clk),
    .por_i  (por_i),
    .we     (sec_we),
    .wdata  (reg_wdata),
    .hw_set (sec_set),
    .hw_clr ('0),
    .q      (sec_q)
  );

  always_comb begin
    case (reg_addr)
      1'b0:    reg_rdata = prim_q;
      default: reg_rdata = sec_q;
    endcase
  end
endmodule

// File: rtl/rc_status_checker.sv
module rc_status_checker
  import rc_status_pkg::*;
(
  input logic             clk,
  input logic             por_i,
  input logic             ev_trap,
  input logic             ev_wdt_timeout,
  input logic             instr_clrwdt,
  input logic             instr_pwrsav,
  input logic             pwrsav_mode,
  input logic             deep_sleep_en,
  input logic             prim_we,
  input logic [REG_W-1:0] prim_set,
  input logic [REG_W-1:0] sec_set,
  input logic [REG_W-1:0] prim_q,
  input logic [REG_W-1:0] sec_q
);
  assert_trap_sets_R2: assert property (@(posedge clk) disable iff (por_i)
    ev_trap |=> prim_q[P_TRAP]);

  assert_sleep_sets_R3: assert property (@(posedge clk) disable iff (por_i)
    (instr_pwrsav && !pwrsav_mode) |=> prim_q[P_SLEEP]);

  assert_deep_sets_R3: assert property (@(posedge clk) disable iff (por_i)
    (instr_pwrsav && !pwrsav_mode && deep_sleep_en) |=> prim_q[P_DEEP]);

  assert_wdt_clear_R4: assert property (@(posedge clk) disable iff (por_i)
    ((instr_clrwdt || instr_pwrsav) && !ev_wdt_timeout) |=> !prim_q[P_WDT]);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (por_i)
    ev_wdt_timeout |=> prim_q[P_WDT]);

  assert_unused_zero_R5: assert property (@(posedge clk) disable iff (por_i)
    (prim_q & ~prim_impl()) == '0);

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (por_i)
    sec_q[REG_W-1:S_FLAGS] == '0);

  assert_no_sw_set_R6: assert property (@(posedge clk) disable iff (por_i)
    (sec_set == '0) |=> ((sec_q & ~$past(sec_q)) == '0));

  assert_sticky_R11: assert property (@(posedge clk) disable iff (por_i)
    (prim_set == '0 && !instr_clrwdt && !instr_pwrsav && !prim_we) |=> $stable(prim_q));
endmodule

bind rc_status_top rc_status_checker u_chk (
  .clk            (clk),
  .por_i          (por_i),
  .ev_trap        (ev_trap),
  .ev_wdt_timeout (ev_wdt_timeout),
  .instr_clrwdt   (instr_clrwdt),
  .instr_pwrsav   (instr_pwrsav),
  .pwrsav_mode    (pwrsav_mode),
  .deep_sleep_en  (deep_sleep_en),
  .prim_we        (prim_we),
  .prim_set       (prim_set),
  .sec_set        (sec_set),
  .prim_q         (prim_q),
  .sec_q          (sec_q)
);

// File: tb/sim_rc_status_top.sv
`timescale 1ns/1ps
module sim_rc_status_top;
  logic clk = 1'b0;
  logic por_i = 1'b1;
  logic ev_trap = 0, ev_illegal = 0, ev_cfg_mismatch = 0, ev_ext_pin = 0;
  logic ev_sw_reset = 0, ev_wdt_timeout = 0, ev_brownout = 0;
  logic instr_clrwdt = 0, instr_pwrsav = 0, pwrsav_mode = 0, deep_sleep_en = 0;
  logic ev_vdd_bor = 0, ev_vdd_por = 0, ev_vbat_por = 0, ev_vbat_exit = 0;
  logic reg_we = 0, reg_addr = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Implemented primary bits: 15,14,10,9,7,6,4,3,2,1,0
  localparam logic [15:0] PMASK = 16'hC000 + 16'h0400 + 16'h0200 + 16'h0080 +
                                  16'h0040 + 16'h001F;

  always #5 clk = ~clk;

  rc_status_top u0 (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input logic a);
    return 16'h0;
  endfunction

  task automatic peek(input logic a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // Apply one clock edge with whatever was driven, then drop all pulses.
  task automatic step();
    @(posedge clk);
    #1;
    ev_trap = 0; ev_illegal = 0; ev_cfg_mismatch = 0; ev_ext_pin = 0;
    ev_sw_reset = 0; ev_wdt_timeout = 0; ev_brownout = 0;
    instr_clrwdt = 0; instr_pwrsav = 0;
    ev_vdd_bor = 0; ev_vdd_por = 0; ev_vbat_por = 0; ev_vbat_exit = 0;
    reg_we = 0;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, pexp, sexp;
    @(posedge clk); #1;
    step(); step();
    por_i = 0;
    peek(0, v); chk("R1 primary reset value", v, 16'h0003);
    peek(1, v); chk("R1 secondary reset value", v, 16'h000E);

    // R2: each primary event alone, accumulating
    pexp = 16'h0003;
    for (int k = 0; k < 7; k++) begin
      case (k)
        0: begin ev_trap = 1;         pexp |= 16'h8000; end
        1: begin ev_illegal = 1;      pexp |= 16'h4000; end
        2: begin ev_cfg_mismatch = 1; pexp |= 16'h0200; end
        3: begin ev_ext_pin = 1;      pexp |= 16'h0080; end
        4: begin ev_sw_reset = 1;     pexp |= 16'h0040; end
        5: begin ev_wdt_timeout = 1;  pexp |= 16'h0010; end
        default: begin ev_brownout = 1; pexp |= 16'h0002; end
      endcase
      step();
      peek(0, v); chk($sformatf("R2 event %0d", k), v, pexp);
    end

    // R11: holds with no activity
    step(); step(); step();
    peek(0, v); chk("R11 primary sticky", v, pexp);
    peek(1, v); chk("R11 secondary sticky", v, 16'h000E);

    // R4: clear-watchdog instruction
    instr_clrwdt = 1; step();
    pexp &= ~16'h0010;
    peek(0, v); chk("R4 clrwdt clears bit 4", v, pexp);

    // R3: power-save modes; R4: power-save also clears watchdog
    ev_wdt_timeout = 1; step(); pexp |= 16'h0010;
    instr_pwrsav = 1; pwrsav_mode = 0; deep_sleep_en = 0; step();
    pexp = (pexp | 16'h0008) & ~16'h0010;
    peek(0, v); chk("R3 R4 sleep without deep", v, pexp);
    instr_pwrsav = 1; pwrsav_mode = 0; deep_sleep_en = 1; step();
    pexp |= 16'h0400;
    peek(0, v); chk("R3 sleep with deep", v, pexp);
    instr_pwrsav = 1; pwrsav_mode = 1; deep_sleep_en = 1; step();
    pexp |= 16'h0004;
    peek(0, v); chk("R3 idle mode", v, pexp);
    deep_sleep_en = 0; pwrsav_mode = 0;

    // R9: set beats instruction clear and software write
    ev_wdt_timeout = 1; instr_clrwdt = 1; step();
    pexp |= 16'h0010;
    peek(0, v); chk("R9 wdt set beats clrwdt", v, pexp);
    ev_wdt_timeout = 1; instr_pwrsav = 1; pwrsav_mode = 1; step();
    pexp |= 16'h0004;
    peek(0, v); chk("R9 wdt set beats pwrsav clear", v, pexp);
    ev_trap = 1; wr(0, 16'h0000);
    peek(0, v); chk("R9 trap set beats write 0", v, 16'h8000);

    // R5: write sweep over the primary register
    wr(0, 16'hFFFF);
    peek(0, v); chk("R5 write all ones", v, PMASK);
    for (int b = 0; b < 16; b++) begin
      wr(0, 16'(1) << b);
      peek(0, v); chk($sformatf("R5 single bit %0d", b), v, (16'(1) << b) & PMASK);
    end
    wr(0, 16'h0000);
    peek(0, v); chk("R5 software clears all", v, 16'h0000);

    // R6 R7: secondary write cannot set, upper bits stay 0
    peek(1, v); chk("R10 secondary untouched by primary writes", v, 16'h000E);
    wr(1, 16'hFFFF);
    peek(1, v); chk("R6 R7 write ones to secondary", v, 16'h000E);

    // R8: each secondary set alone from zero
    for (int b = 0; b < 4; b++) begin
      wr(1, 16'h0000);
      case (b)
        0: ev_vbat_exit = 1;
        1: ev_vbat_por = 1;
        2: ev_vdd_por = 1;
        default: ev_vdd_bor = 1;
      endcase
      step();
      peek(1, v); chk($sformatf("R8 secondary event bit %0d", b), v, 16'(1) << b);
    end

    // R6 R7: clear-only sweep from all-set
    for (int p = 0; p < 16; p++) begin
      ev_vdd_bor = 1; ev_vdd_por = 1; ev_vbat_por = 1; ev_vbat_exit = 1; step();
      wr(1, 16'hFFF0 | 16'(p));
      sexp = 16'(p);
      peek(1, v); chk($sformatf("R6 R7 clear pattern %0d", p), v, sexp);
    end
    peek(0, v); chk("R10 primary untouched by secondary writes", v, 16'h0000);

    // R9: secondary set beats clear write
    ev_vdd_bor = 1; wr(1, 16'h0000);
    peek(1, v); chk("R9 secondary set beats clear", v, 16'h0008);

    // R1: power-on reset again from an arbitrary state
    ev_trap = 1; wr(0, 16'h0F0F);
    por_i = 1; step(); por_i = 0;
    peek(0, v); chk("R1 re-reset primary", v, 16'h0003);
    peek(1, v); chk("R1 re-reset secondary", v, 16'h000E);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule